// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the software-visible register file of a color LCD controller. A host reaches it over a simple 32-bit bus that spans a 4 KB window. The block stores four panel timing words, the base addresses of the upper and lower panel frame buffers, an interrupt mask and a control word. It keeps a set of interrupt status bits that hardware event pulses set and that software clears by writing ones. The top of the window holds a fixed, read-only identification table.

The block also produces the signals that the display pipeline needs. These are the active column and row counts, which it decodes from packed timing fields, and a display enable that needs both an enable bit and a power bit. It also drives the pixel-depth and ordering selects and an interrupt line that is high while any unmasked status bit is set. The bus side is single-cycle. An access is presented for one clock. Read data and the error flag come back registered in the cycle that follows.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every stored register and every status bit is zero. As a result `disp_en` is 0, `irq_out` is 0, `panel_cols` is 16 and `panel_rows` is 1.
- R2: The writable registers are at byte offsets 0x00 to 0x1C: timing 0-3, upper base, lower base, mask and control. Each reads back what was written. The mask keeps only its low IRQ_W bits and reads zero above them.
- R3: `panel_cols` equals ((timing0 & 0xFC) + 4) * 4.
- R4: `panel_rows` equals (timing1 & 0x3FF) + 1.
- R5: `disp_en` is 1 only when control bit 0 and control bit 11 are both 1.
- R6: `pix_depth` is control bits [3:1]. `bgr_sel` is bit 8, `be_byte` is bit 9 and `be_pix` is bit 10.
- R7: A 1 on `irq_event[i]` sets status bit i. A read at 0x20 returns the raw status. A read at 0x24 returns status AND mask.
- R8: A write at 0x28 clears every status bit whose data bit is 1. If an event arrives for the same bit in the same cycle, the bit stays set.
- R9: `irq_out` is 1 exactly when status AND mask is nonzero.
- R10: Reads at 0xFE0, 0xFE4, ... 0xFFC return one ID byte each, in this order: 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with the upper 24 bits zero.
- R11: The following accesses are illegal and change no state: any unmapped offset, a write to 0x20, 0x24 or the ID area, and a read of 0x28. An illegal read returns zero. Each illegal access raises `bus_err` for exactly the following cycle, and a legal access never raises it.
- R12: Read data appears on `bus_rdata` in the cycle after the access. In every other cycle `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Word address, byte-address bits [11:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Illegal-access flag, one cycle after the access |
| irq_event | input | IRQ_W | Interrupt source pulses |
| irq_out | output | 1 | Combined masked interrupt |
| panel_cols | output | COL_W | Active pixels per line |
| panel_rows | output | ROW_W | Active lines per panel |
| upper_base | output | 32 | Upper panel frame base address |
| lower_base | output | 32 | Lower panel frame base address |
| disp_en | output | 1 | Enable and power both set |
| pix_depth | output | 3 | Bits-per-pixel mode select |
| bgr_sel | output | 1 | Blue/red swap |
| be_byte | output | 1 | Big-endian byte order |
| be_pix | output | 1 | Big-endian pixel order within a byte |

## Verification
The geometry decode is driven to its extremes: the 1024 maximum for both dimensions, with junk in the unused timing bits, and the 16-by-1 reset default. A decoder that kept the low two timing bits, or one that missed the +1 row offset, would give counts that are off by a few pixels or by one line. The enable test sets the enable and power bits each alone and then together; a design that used OR would light the panel early. The interrupt tests clear bits selectively, change the mask while status is held, and collide a clear with an event on the same bit. Here a design with the wrong priority would drop a fresh event. The illegal-access tests write to the read-only status and ID locations and then read the state back. They also check that the error flag falls after one cycle, which catches a sticky flag or a write that leaks through.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WORD_W = ADDR_W - 2;
    localparam int ID_N   = 8;
    localparam int ID_IW  = $clog2(ID_N);

    // word offsets whose position is visible to software
    localparam logic [WORD_W-1:0] W_RAW  = WORD_W'(8);
    localparam logic [WORD_W-1:0] W_MIS  = WORD_W'(9);
    localparam logic [WORD_W-1:0] W_ICLR = WORD_W'(10);
    localparam logic [WORD_W-1:0] W_ID0  = WORD_W'((1 << WORD_W) - ID_N);

    typedef enum logic [3:0] {
        SEL_NONE, SEL_T0, SEL_T1, SEL_T2, SEL_T3, SEL_UBASE, SEL_LBASE,
        SEL_MASK, SEL_CTRL, SEL_RAW, SEL_MIS, SEL_ICLR, SEL_ID
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] t0;
        logic [DATA_W-1:0] t1;
        logic [DATA_W-1:0] t2;
        logic [DATA_W-1:0] t3;
        logic [DATA_W-1:0] ubase;
        logic [DATA_W-1:0] lbase;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;

    function automatic logic [7:0] id_byte(input logic [ID_IW-1:0] idx);
        case (idx)
            3'd0:    return 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              illegal
);
    always_comb begin
        sel = SEL_NONE;
        if (word >= W_ID0) begin
            sel = SEL_ID;
        end else begin
            case (word)
                WORD_W'(0): sel = SEL_T0;
                WORD_W'(1): sel = SEL_T1;
                WORD_W'(2): sel = SEL_T2;
                WORD_W'(3): sel = SEL_T3;
                WORD_W'(4): sel = SEL_UBASE;
                WORD_W'(5): sel = SEL_LBASE;
                WORD_W'(6): sel = SEL_MASK;
                WORD_W'(7): sel = SEL_CTRL;
                W_RAW:      sel = SEL_RAW;
                W_MIS:      sel = SEL_MIS;
                W_ICLR:     sel = SEL_ICLR;
                default:    sel = SEL_NONE;
            endcase
        end
        illegal = (sel == SEL_NONE)
                || (wr  && (sel == SEL_RAW || sel == SEL_MIS || sel == SEL_ID))
                || (!wr && (sel == SEL_ICLR));
    end
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
    parameter int COL_W = 11,
    parameter int ROW_W = 11
) (
    input  logic [5:0]       col_field,
    input  logic [9:0]       row_field,
    output logic [COL_W-1:0] cols,
    output logic [ROW_W-1:0] rows
);
    localparam int CU_W = 7;
    logic [CU_W-1:0] col_units;
    logic [10:0]     row_sum;

    always_comb begin
        // ((v & 0xFC) + 4) * 4 == (v[7:2] + 1) * 16
        col_units = {1'b0, col_field} + CU_W'(1);
        cols      = COL_W'({col_units, 4'b0000});
        row_sum   = {1'b0, row_field} + 11'd1;
        rows      = ROW_W'(row_sum);
    end
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
    parameter int IRQ_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] evt,
    input  logic             clr_en,
    input  logic [IRQ_W-1:0] clr_bits,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] status,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    logic [IRQ_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_en) stat_d = stat_d & ~clr_bits;
        stat_d = stat_d | evt;   // a new event beats a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status = stat_q;
    assign masked = stat_q & mask;
    assign irq    = |masked;
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter int IRQ_W = 5,
    parameter int COL_W = 11,
    parameter int ROW_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:2] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [IRQ_W-1:0]  irq_event,
    output logic              irq_out,
    output logic [COL_W-1:0]  panel_cols,
    output logic [ROW_W-1:0]  panel_rows,
    output logic [DATA_W-1:0] upper_base,
    output logic [DATA_W-1:0] lower_base,
    output logic              disp_en,
    output logic [2:0]        pix_depth,
    output logic              bgr_sel,
    output logic              be_byte,
    output logic              be_pix
);
    localparam logic [DATA_W-1:0] MASK_KEEP = DATA_W'((64'd1 << IRQ_W) - 64'd1);

    regs_t            r_d, r_q;
    reg_sel_e         sel;
    logic             illegal;
    logic             acc_ok;
    logic [IRQ_W-1:0] status_w, masked_w;

    lcdc_decode u_dec (
        .word    (bus_addr),
        .wr      (bus_wr),
        .sel     (sel),
        .illegal (illegal)
    );

    assign acc_ok = bus_sel && !illegal;

    lcdc_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (irq_event),
        .clr_en   (acc_ok && bus_wr && sel == SEL_ICLR),
        .clr_bits (bus_wdata[IRQ_W-1:0]),
        .mask     (r_q.mask[IRQ_W-1:0]),
        .status   (status_w),
        .masked   (masked_w),
        .irq      (irq_out)
    );

    lcdc_geom #(.COL_W(COL_W), .ROW_W(ROW_W)) u_geom (
        .col_field (r_q.t0[7:2]),
        .row_field (r_q.t1[9:0]),
        .cols      (panel_cols),
        .rows      (panel_rows)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rdata = '0;
        r_d.err   = bus_sel && illegal;
        if (acc_ok && bus_wr) begin
            case (sel)
                SEL_T0:    r_d.t0    = bus_wdata;
                SEL_T1:    r_d.t1    = bus_wdata;
                SEL_T2:    r_d.t2    = bus_wdata;
                SEL_T3:    r_d.t3    = bus_wdata;
                SEL_UBASE: r_d.ubase = bus_wdata;
                SEL_LBASE: r_d.lbase = bus_wdata;
                SEL_MASK:  r_d.mask  = bus_wdata & MASK_KEEP;
                SEL_CTRL:  r_d.ctrl  = bus_wdata;
                default:   ;
            endcase
        end
        if (acc_ok && !bus_wr) begin
            case (sel)
                SEL_T0:    r_d.rdata = r_q.t0;
                SEL_T1:    r_d.rdata = r_q.t1;
                SEL_T2:    r_d.rdata = r_q.t2;
                SEL_T3:    r_d.rdata = r_q.t3;
                SEL_UBASE: r_d.rdata = r_q.ubase;
                SEL_LBASE: r_d.rdata = r_q.lbase;
                SEL_MASK:  r_d.rdata = r_q.mask;
                SEL_CTRL:  r_d.rdata = r_q.ctrl;
                SEL_RAW:   r_d.rdata = DATA_W'(status_w);
                SEL_MIS:   r_d.rdata = DATA_W'(masked_w);
                SEL_ID:    r_d.rdata = DATA_W'(id_byte(bus_addr[ID_IW+1:2]));
                default:   r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata  = r_q.rdata;
    assign bus_err    = r_q.err;
    assign upper_base = r_q.ubase;
    assign lower_base = r_q.lbase;
    assign disp_en    = r_q.ctrl[0] & r_q.ctrl[11];
    assign pix_depth  = r_q.ctrl[3:1];
    assign bgr_sel    = r_q.ctrl[8];
    assign be_byte    = r_q.ctrl[9];
    assign be_pix     = r_q.ctrl[10];
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
    parameter int IRQ_W = 5,
    parameter int COL_W = 11,
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [11:2]      bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             bus_err,
    input logic [IRQ_W-1:0] irq_event,
    input logic [IRQ_W-1:0] status,
    input logic [COL_W-1:0] panel_cols,
    input logic [ROW_W-1:0] panel_rows,
    input logic [31:0]      upper_base
);
    // R11
    err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_err);

    // R11
    idle_keeps_config_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> ($stable(panel_cols) && $stable(panel_rows) && $stable(upper_base)));

    // R7
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_event) |=> ((status & $past(irq_event)) == $past(irq_event)));

    // R8
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 10'd10) |=>
        ((status & $past(bus_wdata[IRQ_W-1:0]) & ~$past(irq_event)) == '0));

    // R7
    masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 10'd9) |=>
        ((bus_rdata & ~32'($past(status))) == 32'd0));

    // R10
    id_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[11:5] == 7'h7F) |=> (bus_rdata[31:8] == 24'd0));

    // R12
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (bus_rdata == 32'd0));
endmodule

bind lcdc_regs lcdc_regs_chk #(.IRQ_W(IRQ_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .irq_event  (irq_event),
    .status     (status_w),
    .panel_cols (panel_cols),
    .panel_rows (panel_rows),
    .upper_base (upper_base)
);

// File: tb/lcdc_regs_test.sv
module lcdc_regs_test;
    localparam int IRQ_W = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:2] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [IRQ_W-1:0] irq_event = '0;
    logic        irq_out, disp_en, bgr_sel, be_byte, be_pix;
    logic [10:0] panel_cols, panel_rows;
    logic [31:0] upper_base, lower_base;
    logic [2:0]  pix_depth;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lcdc_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq_event(irq_event), .irq_out(irq_out),
        .panel_cols(panel_cols), .panel_rows(panel_rows),
        .upper_base(upper_base), .lower_base(lower_base), .disp_en(disp_en),
        .pix_depth(pix_depth), .bgr_sel(bgr_sel), .be_byte(be_byte), .be_pix(be_pix)
    );

    // {byte address, write data, expected readback}
    localparam logic [75:0] VEC [8] = '{
        {12'h000, 32'hA5A5_13FC, 32'hA5A5_13FC},
        {12'h004, 32'h1234_57FF, 32'h1234_57FF},
        {12'h008, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {12'h00C, 32'h0000_FFFF, 32'h0000_FFFF},
        {12'h010, 32'h8000_0000, 32'h8000_0000},
        {12'h014, 32'h0123_4567, 32'h0123_4567},
        {12'h018, 32'hFFFF_FFFF, 32'h0000_001F},
        {12'h01C, 32'h0000_0000, 32'h0000_0000}
    };

    localparam logic [7:0] IDS [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[11:2]; bus_wdata = d;
        @(negedge clk);
        e = bus_err;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[11:2];
        @(negedge clk);
        d = bus_rdata; e = bus_err;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [IRQ_W-1:0] v);
        @(negedge clk); irq_event = v;
        @(negedge clk); irq_event = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cols", 32'(panel_cols), 32'd16);
        chk("R1 rows", 32'(panel_rows), 32'd1);
        chk("R1 en/irq", {30'd0, disp_en, irq_out}, 32'd0);
        bread(12'h01C, d, e);
        chk("R1 ctrl", d, 32'd0);
        bread(12'h020, d, e);
        chk("R1 status", d, 32'd0);

        // R2 table of writes and readbacks
        for (int i = 0; i < 8; i++) begin
            bwrite(VEC[i][75:64], VEC[i][63:32], e);
            chk("R11 legal write err", 32'(e), 32'd0);
            bread(VEC[i][75:64], d, e);
            chk("R2 readback", d, VEC[i][31:0]);
        end
        chk("R3 max cols", 32'(panel_cols), 32'd1024);
        chk("R4 max rows", 32'(panel_rows), 32'd1024);
        chk("R2 upper base", upper_base, 32'h8000_0000);
        chk("R2 lower base", lower_base, 32'h0123_4567);

        // R12 idle cycle has zero read data
        @(negedge clk);
        chk("R12 idle rdata", bus_rdata, 32'd0);

        bwrite(12'h000, 32'h0000_0028, e);
        chk("R3 cols 176", 32'(panel_cols), 32'd176);
        bwrite(12'h000, 32'h0000_002B, e);
        chk("R3 low bits ignored", 32'(panel_cols), 32'd176);
        bwrite(12'h004, 32'hFFFF_F0EF, e);
        chk("R4 rows 240", 32'(panel_rows), 32'd240);

        // R5 enable needs both bits
        bwrite(12'h01C, 32'h0000_0001, e);
        chk("R5 enable only", 32'(disp_en), 32'd0);
        bwrite(12'h01C, 32'h0000_0800, e);
        chk("R5 power only", 32'(disp_en), 32'd0);
        bwrite(12'h01C, 32'h0000_0801, e);
        chk("R5 both", 32'(disp_en), 32'd1);

        // R6 format fields
        bwrite(12'h01C, 32'h0000_070A, e);
        chk("R6 fields", {26'd0, pix_depth, bgr_sel, be_byte, be_pix}, {26'd0, 3'd5, 3'b111});
        bwrite(12'h01C, 32'h0000_0204, e);
        chk("R6 fields 2", {26'd0, pix_depth, bgr_sel, be_byte, be_pix}, {26'd0, 3'd2, 3'b010});

        // R7 / R9 interrupts
        bwrite(12'h018, 32'h0, e);
        pulse(5'b10110);
        bread(12'h020, d, e);
        chk("R7 raw", d, 32'h16);
        bread(12'h024, d, e);
        chk("R7 masked zero", d, 32'h0);
        chk("R9 irq low", 32'(irq_out), 32'd0);
        bwrite(12'h018, 32'h0000_0004, e);
        chk("R9 irq high", 32'(irq_out), 32'd1);
        bread(12'h024, d, e);
        chk("R7 masked", d, 32'h04);

        // R8 selective clear
        bwrite(12'h028, 32'h0000_0006, e);
        chk("R8 clear err", 32'(e), 32'd0);
        chk("R9 irq after clear", 32'(irq_out), 32'd0);
        bread(12'h020, d, e);
        chk("R8 raw after clear", d, 32'h10);

        // R8 event beats clear
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'd10; bus_wdata = 32'h11;
        irq_event = 5'b10000;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; irq_event = '0;
        bread(12'h020, d, e);
        chk("R8 collision", d, 32'h10);

        // R10 ID table
        for (int k = 0; k < 8; k++) begin
            bread(12'hFE0 + 12'(4 * k), d, e);
            chk("R10 id byte", d, 32'(IDS[k]));
            chk("R11 id read err", 32'(e), 32'd0);
        end

        // R11 illegal accesses
        bwrite(12'h030, 32'hFFFF_FFFF, e);
        chk("R11 unmapped write err", 32'(e), 32'd1);
        @(negedge clk);
        chk("R11 err one cycle", 32'(bus_err), 32'd0);
        bread(12'h030, d, e);
        chk("R11 unmapped read data", d, 32'd0);
        chk("R11 unmapped read err", 32'(e), 32'd1);
        bread(12'h028, d, e);
        chk("R11 clear-reg read err", 32'(e), 32'd1);
        bread(12'h200, d, e);
        chk("R11 palette area read", {d[30:0], e}, 32'd1);
        bwrite(12'h020, 32'h0000_0000, e);
        chk("R11 raw write err", 32'(e), 32'd1);
        bread(12'h020, d, e);
        chk("R11 raw unchanged", d, 32'h10);
        bwrite(12'hFE0, 32'h0000_0000, e);
        chk("R11 id write err", 32'(e), 32'd1);
        bread(12'hFE0, d, e);
        chk("R11 id unchanged", d, 32'h10);
        chk("R11 geometry kept", {5'd0, panel_cols, 5'd0, panel_rows}, {5'd0, 11'd176, 5'd0, 11'd240});

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule